// File: doc/BRIEF.md
# Quad DAC Serial Control Interface

This block is the digital front end of a four-channel, 8-bit converter. A host drives it over a three-wire synchronous link with a serial clock, an active-low select and a data line. Each transfer carries a 12-bit command made of a channel address, a two-bit operation and a data byte. The command is decoded from the last twelve bits shifted in and runs when the select line is released. Each channel has two registers. The staging (input) register takes new data. The output register holds the code the converter uses. Operations can fill the staging register, copy every staging register to its output register, or do both at once.

The serial output repeats every shifted bit twelve serial clocks later. A host can therefore chain several devices, or read back what it sent. An operation selects whether this output changes on the rising or the falling serial-clock edge. Two active-low side inputs act on all four channels. One is a load strobe that keeps copying the staging registers into the output registers while it is held low. The other is a clear that zeroes every register while it is held low. All pins are sampled by a faster system clock through two-flop synchronizers, and the block works from the synchronized edges.

Top module: `quad_dac_serial_ctrl`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts `din` into a 12-bit history. When `cs_n` rises, only the last 12 bits are decoded, so a 16-bit transfer drops its first four bits. A transfer may pause with `sclk` low between bits.
- R2: A command executes on the rising edge of `cs_n`. The frame is sent MSB first: bits 11:10 are the channel (0 to 3), bits 9:8 are the operation and bits 7:0 are the data. Channel c drives `dac_code[c]`, and only an executed command, the load strobe or the clear changes `dac_code`.
- R3: Operation 00 writes the data into the addressed channel's staging register and leaves every `dac_code` unchanged.
- R4: Operation 01 writes the staging register of the addressed channel. All four output registers then take their staging values, including the new byte.
- R5: Operation 10 copies all staging registers into the output registers and changes no staging register.
- R6: Operation 11 sets the serial-output edge from data bit 0 (1 = rising, 0 = falling) and changes no register of any channel.
- R7: In rising mode, at each rising edge of `sclk` with `cs_n` low, `dout` takes the bit shifted in 12 rising edges earlier. This history carries across transfers, and it is zero for positions before the first bit after reset.
- R8: In falling mode, `dout` takes that same delayed bit on the following falling edge of `sclk`, and it does not change on the rising edge.
- R9: While `cs_n` is high, `sclk` and `din` have no effect: `dout`, the history and every register keep their values.
- R10: While `load_n` is low, every output register keeps copying its staging register. A staging write made during that time reaches `dac_code` without any further command.
- R11: While `clear_n` is low, all staging and output registers are zero. The clear overrides commands and the load strobe, and a write made during the clear is lost.
- R12: After `rst_n` is asserted, all registers and the history are zero, `dout` is 0 and the serial output is in rising mode.
- R13: A change on `cs_n`, `sclk`, `load_n` or `clear_n` takes effect at the third rising edge of `clk` after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; its rising edge executes the command |
| din | input | 1 | Serial data in, MSB first |
| load_n | input | 1 | Active-low level strobe copying all staging registers to outputs |
| clear_n | input | 1 | Active-low clear of all channel registers |
| dout | output | 1 | Serial data out, 12-clock delayed copy of `din` |
| dac_code | output | NUM_CH x DATA_W | Output register contents, channel c at `dac_code[c]` |

## Verification
The bench goes after the corner cases that are easy to get wrong. A 16-bit or split transfer would decode the wrong field if the decoder counted bits instead of using the last twelve. A wrong echo depth, or a history reset at each select, would show up as a shifted or zeroed `dout` sequence across transfers. A wrong clock edge in falling mode would make `dout` change a half period early. Toggling `sclk` with the select high would leak bits into the history if the gating were wrong. The bench also holds the load strobe low during a staging write, which would go unseen if the strobe were edge-triggered. It sends a write while the clear is held, which would stick if the clear did not take priority. Finally it counts system clocks after `cs_n` rises and expects the new code at the third edge exactly.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;

  localparam int CTRL_W = 2;

  typedef enum logic [CTRL_W-1:0] {
    OP_STAGE      = 2'b00,
    OP_STAGE_MOVE = 2'b01,
    OP_MOVE       = 2'b10,
    OP_EDGE_SEL   = 2'b11
  } qdac_op_e;

  // operation writes the staging register of the addressed channel
  function automatic logic op_stages(qdac_op_e op);
    return (op == OP_STAGE) || (op == OP_STAGE_MOVE);
  endfunction

  // operation copies every staging register to its output register
  function automatic logic op_moves(qdac_op_e op);
    return (op == OP_STAGE_MOVE) || (op == OP_MOVE);
  endfunction

  // operation reprograms the serial-output edge
  function automatic logic op_edge(qdac_op_e op);
    return op == OP_EDGE_SEL;
  endfunction

  function automatic logic edge_up(logic cur, logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic edge_down(logic cur, logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/qdac_sync.sv
`timescale 1ns/1ps
module qdac_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/qdac_shifter.sv
`timescale 1ns/1ps
module qdac_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en_i,
  input  logic               fall_en_i,
  input  logic               din_i,
  input  logic               rise_mode_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               dout_o
);

  logic [FRAME_W-1:0] frame_q;
  logic               pend_q;
  logic               dout_q;
  logic               oldest;

  assign oldest = frame_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      pend_q  <= 1'b0;
      dout_q  <= 1'b0;
    end else if (shift_en_i) begin
      frame_q <= {frame_q[FRAME_W-2:0], din_i};
      pend_q  <= oldest;
      if (rise_mode_i) begin
        dout_q <= oldest;
      end
    end else if (fall_en_i && !rise_mode_i) begin
      dout_q <= pend_q;
    end
  end

  assign frame_o = frame_q;
  assign dout_o  = dout_q;

endmodule

// File: rtl/qdac_latches.sv
`timescale 1ns/1ps
module qdac_latches
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           load_i,
  input  logic                           exec_i,
  input  qdac_op_e                       op_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  in_code_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  out_code_o
);

  logic move_all;
  assign move_all = exec_i && op_moves(op_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] hold_q;
    logic              hit;
    logic              wr;

    assign hit = exec_i && (addr_i == ADDR_W'(g));
    assign wr  = hit && op_stages(op_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        hold_q  <= '0;
      end else if (clear_i) begin
        stage_q <= '0;
        hold_q  <= '0;
      end else begin
        if (wr) begin
          stage_q <= data_i;
        end
        if (load_i) begin
          hold_q <= stage_q;
        end else if (move_all) begin
          hold_q <= wr ? data_i : stage_q;
        end
      end
    end

    assign in_code_o[g]  = stage_q;
    assign out_code_o[g] = hold_q;
  end

endmodule

// File: rtl/quad_dac_serial_ctrl.sv
`timescale 1ns/1ps
module quad_dac_serial_ctrl
  import qdac_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk,
  input  logic                          cs_n,
  input  logic                          din,
  input  logic                          load_n,
  input  logic                          clear_n,
  output logic                          dout,
  output logic [NUM_CH-1:0][DATA_W-1:0] dac_code
);

  localparam int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int FRAME_W = ADDR_W + CTRL_W + DATA_W;
  localparam int PIN_W   = 5;
  // pin order in the synchronizer: {din, clear_n, load_n, cs_n, sclk}
  localparam logic [PIN_W-1:0] PIN_IDLE = 5'b01110;

  logic [PIN_W-1:0] pins_s;
  logic             sclk_s, cs_low, din_s, load_act, clear_act;
  logic             sclk_prev_q, cs_low_prev_q;
  logic             sclk_rise, sclk_fall, cs_rise;
  logic             rise_mode;
  logic [FRAME_W-1:0] frame;
  logic [NUM_CH-1:0][DATA_W-1:0] in_code;
  logic [ADDR_W-1:0] cmd_addr;
  qdac_op_e          cmd_op;
  logic [DATA_W-1:0] cmd_data;

  qdac_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({din, clear_n, load_n, cs_n, sclk}),
    .q_o   (pins_s)
  );

  assign sclk_s    = pins_s[0];
  assign cs_low    = ~pins_s[1];
  assign load_act  = ~pins_s[2];
  assign clear_act = ~pins_s[3];
  assign din_s     = pins_s[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q   <= 1'b0;
      cs_low_prev_q <= 1'b0;
    end else begin
      sclk_prev_q   <= sclk_s;
      cs_low_prev_q <= cs_low;
    end
  end

  assign sclk_rise = edge_up(sclk_s, sclk_prev_q);
  assign sclk_fall = edge_down(sclk_s, sclk_prev_q);
  assign cs_rise   = edge_down(cs_low, cs_low_prev_q);

  qdac_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en_i  (sclk_rise && cs_low),
    .fall_en_i   (sclk_fall && cs_low),
    .din_i       (din_s),
    .rise_mode_i (rise_mode),
    .frame_o     (frame),
    .dout_o      (dout)
  );

  assign cmd_addr = frame[FRAME_W-1 -: ADDR_W];
  assign cmd_op   = qdac_op_e'(frame[DATA_W +: CTRL_W]);
  assign cmd_data = frame[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_mode <= 1'b1;
    end else if (cs_rise && op_edge(cmd_op)) begin
      rise_mode <= cmd_data[0];
    end
  end

  qdac_latches #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_act),
    .load_i     (load_act),
    .exec_i     (cs_rise),
    .op_i       (cmd_op),
    .addr_i     (cmd_addr),
    .data_i     (cmd_data),
    .in_code_o  (in_code),
    .out_code_o (dac_code)
  );

endmodule

// File: rtl/qdac_chk.sv
`timescale 1ns/1ps
module qdac_chk #(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          din_s,
  input logic                          sclk_rise,
  input logic                          cs_low,
  input logic                          cs_rise,
  input logic                          load_act,
  input logic                          clear_act,
  input logic                          rise_mode,
  input logic                          dout,
  input logic [FRAME_W-1:0]            frame,
  input logic [NUM_CH-1:0][DATA_W-1:0] in_code,
  input logic [NUM_CH-1:0][DATA_W-1:0] dac_code
);

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cs_low) |=> (frame[0] == $past(din_s)));

  // R9
  frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && cs_low) |=> $stable(frame));

  // R9
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> $stable(dout));

  // R7
  echo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_mode && sclk_rise && cs_low) |=> (dout == $past(frame[FRAME_W-1])));

  // R8
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_mode && sclk_rise) |=> $stable(dout));

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_act |=> ((dac_code == '0) && (in_code == '0)));

  // R10
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && !clear_act) |=> (dac_code == $past(in_code)));

  // R2
  dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_rise || load_act || clear_act) |=> $stable(dac_code));

endmodule

bind quad_dac_serial_ctrl qdac_chk #(
  .NUM_CH  (NUM_CH),
  .DATA_W  (DATA_W),
  .FRAME_W (FRAME_W)
) u_qdac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din_s     (din_s),
  .sclk_rise (sclk_rise),
  .cs_low    (cs_low),
  .cs_rise   (cs_rise),
  .load_act  (load_act),
  .clear_act (clear_act),
  .rise_mode (rise_mode),
  .dout      (dout),
  .frame     (frame),
  .in_code   (in_code),
  .dac_code  (dac_code)
);

// File: tb/tb_quad_dac_serial_ctrl.sv
`timescale 1ns/1ps
module tb_quad_dac_serial_ctrl;

  localparam int NCH  = 4;
  localparam int DW   = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic load_n = 1'b1;
  logic clear_n = 1'b1;
  logic dout;
  logic [NCH-1:0][DW-1:0] dac_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [DW-1:0] in_m  [NCH];
  logic [DW-1:0] out_m [NCH];
  bit rise_m = 1'b1;
  bit hist_m [0:4095];
  int n_bits = 0;

  always #2 clk = ~clk;

  quad_dac_serial_ctrl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .din      (din),
    .load_n   (load_n),
    .clear_n  (clear_n),
    .dout     (dout),
    .dac_code (dac_code)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bit echoed after shifting bit number idx (0-based since reset)
  function automatic bit echo_at(int idx);
    if (idx < 12) return 1'b0;
    return hist_m[idx-12];
  endfunction

  function automatic logic [15:0] cmd(int a, int op, int d);
    return 16'(((a & 3) << 10) | ((op & 3) << 8) | (d & 255));
  endfunction

  task automatic shift_bit(bit b);
    @(negedge clk);
    din = b;
    sclk = 1'b1;
    hist_m[n_bits] = b;
    n_bits++;
    repeat (HALF) @(negedge clk);
    if (rise_m) check(dout == echo_at(n_bits-1), "R7", int'(dout), int'(echo_at(n_bits-1)));
    else        check(dout == echo_at(n_bits-2), "R8", int'(dout), int'(echo_at(n_bits-2)));
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    if (!rise_m) check(dout == echo_at(n_bits-1), "R8", int'(dout), int'(echo_at(n_bits-1)));
  endtask

  task automatic open_frame();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic model(logic [11:0] w);
    int a;
    int op;
    a  = int'(w[11:10]);
    op = int'(w[9:8]);
    case (op)
      0: in_m[a] = w[7:0];
      1: begin
        in_m[a] = w[7:0];
        for (int c = 0; c < NCH; c++) out_m[c] = in_m[c];
      end
      2: for (int c = 0; c < NCH; c++) out_m[c] = in_m[c];
      default: rise_m = w[0];
    endcase
    if (!load_n) for (int c = 0; c < NCH; c++) out_m[c] = in_m[c];
    if (!clear_n) for (int c = 0; c < NCH; c++) begin in_m[c] = '0; out_m[c] = '0; end
  endtask

  task automatic send(logic [15:0] w, int nb);
    open_frame();
    for (int i = nb-1; i >= 0; i--) shift_bit(w[i]);
    close_frame();
    model(w[11:0]);
  endtask

  task automatic check_outs(string req);
    for (int c = 0; c < NCH; c++)
      check(dac_code[c] == out_m[c], req, int'(dac_code[c]), int'(out_m[c]));
  endtask

  task automatic idle_toggle(int n);
    logic prev;
    prev = dout;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk = 1'b1;
      din  = i[0];
      repeat (HALF) @(negedge clk);
      check(dout == prev, "R9", int'(dout), int'(prev));
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      check(dout == prev, "R9", int'(dout), int'(prev));
    end
    din = 1'b0;
    check_outs("R9");
  endtask

  initial begin
    logic [11:0] w;
    for (int c = 0; c < NCH; c++) begin in_m[c] = '0; out_m[c] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    check_outs("R12");
    check(dout == 1'b0, "R12", int'(dout), 0);

    // R3 then R5: stage every channel, then move all
    for (int c = 0; c < NCH; c++) begin
      send(cmd(c, 0, 8'h11 * (c + 3)), 12);
      check_outs("R3");
    end
    send(cmd(2, 2, 8'hEE), 12);
    check_outs("R5");

    // R4 / R2: sweep channels and data with stage-and-move
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NCH; c++) begin
        int v;
        v = (c * 67 + k * 41 + 5) & 255;
        if (k == 7) v = c[0] ? 8'h00 : 8'hFF;
        send(cmd(c, 1, v), 12);
        check_outs("R4");
      end
    end

    // R3 and R5 again with fresh staging data
    for (int c = 0; c < NCH; c++) begin
      send(cmd(c, 0, 8'h5A ^ (c * 29)), 12);
      check_outs("R3");
    end
    send(cmd(0, 2, 0), 12);
    check_outs("R5");
    send(cmd(1, 2, 8'h99), 12);
    check_outs("R5");

    // R1: 16-bit frame with leading junk, and a split 4+8 transfer
    send(16'hA000 | cmd(2, 1, 8'h3C), 16);
    check_outs("R1");
    w = cmd(3, 1, 8'hC7);
    open_frame();
    for (int i = 11; i >= 8; i--) shift_bit(w[i]);
    repeat (20) @(negedge clk);
    for (int i = 7; i >= 0; i--) shift_bit(w[i]);
    close_frame();
    model(w);
    check_outs("R1");

    // R9: clock and data with select high are ignored
    idle_toggle(6);
    send(cmd(1, 1, 8'h42), 12);
    check_outs("R9");

    // R6 / R8: falling-edge mode
    send(cmd(0, 3, 8'h00), 12);
    check_outs("R6");
    for (int c = 0; c < NCH; c++) begin
      send(cmd(c, 1, 8'hA5 ^ (c * 17)), 12);
      check_outs("R8");
    end
    send(16'h5000 | cmd(1, 1, 8'h81), 16);
    check_outs("R8");
    send(cmd(3, 3, 8'h01), 12);
    check_outs("R6");
    send(cmd(2, 1, 8'h6D), 12);
    check_outs("R7");

    // R10: level load strobe
    for (int c = 0; c < NCH; c++) send(cmd(c, 0, 8'h30 + c * 7), 12);
    check_outs("R3");
    @(negedge clk);
    load_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) out_m[c] = in_m[c];
    check_outs("R10");
    send(cmd(2, 0, 8'hB4), 12);
    check_outs("R10");
    @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    send(cmd(1, 0, 8'h0F), 12);
    check_outs("R10");

    // R11: clear overrides a write in flight
    @(negedge clk);
    clear_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin in_m[c] = '0; out_m[c] = '0; end
    check_outs("R11");
    send(cmd(3, 1, 8'h77), 12);
    check_outs("R11");
    @(negedge clk);
    clear_n = 1'b1;
    repeat (4) @(negedge clk);
    send(cmd(0, 2, 0), 12);
    check_outs("R11");

    // R13: exact latency from select release to new code
    w = cmd(1, 1, 8'h5A);
    open_frame();
    for (int i = 11; i >= 0; i--) shift_bit(w[i]);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dac_code[1] == 8'h00, "R13", int'(dac_code[1]), 0);
    @(negedge clk);
    check(dac_code[1] == 8'h5A, "R13", int'(dac_code[1]), 8'h5A);
    repeat (4) @(negedge clk);
    model(w);
    check_outs("R13");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule